// File: doc/BRIEF.md
# MMU Configuration Register File with Translation Buffer Pointers

This block keeps the configuration state that a memory management unit exposes to software: two context numbers, the tag access value that records the last translation miss, a partition number, and the base and configuration words of the in-memory translation storage buffers. The buffer words come in two sets, one for context zero and one for any nonzero context. Each set has two base registers, one per page-size slot, and a shared configuration word.

Software reaches every register through an address-space class plus a byte offset. A miss update port lets the translation logic load the tag access register directly. On a read, the block also produces two derived values: the tag target, and the buffer pointer for each page-size slot. Each pointer indexes the buffer with the virtual page number taken from the tag access register. The page size and buffer size come from the set that the tag access context selects.

Top module: `mmu_tsb_regfile`

## Requirements
- R1: Every request cycle (req_valid high) produces exactly one response with rsp_valid high on the following cycle; rsp_valid is low after a cycle without a request; write responses and error responses carry rsp_rdata of zero.
- R2: Class 0 holds the primary context at offset 0x8 and the secondary context at offset 0x10; each keeps the low CTX_W bits of the write data and reads back zero-extended.
- R3: In class 1, offset 0x30 holds the 64-bit tag access register and offset 0x80 holds the partition number. The partition number keeps the low PART_W bits of the write data and reads back zero-extended.
- R4: A read of class 1 offset 0x0 returns the tag target. Its bits 41:0 hold tag access bits 63:22, its bits 60:48 hold tag access bits 12:0, and all other bits are zero. The tag target is read-only.
- R5: A miss update loads tag access with miss_va bits 63:13 above miss_ctx bits 12:0. When it occurs in the same cycle as a software write to tag access, the miss update wins.
- R6: Base and configuration registers sit at offset 0 of their own classes, each storing all 64 bits. For context zero, class 2 is the slot 0 base, class 3 the slot 1 base and class 4 the config. For nonzero context, classes 5, 6 and 7 hold the same three registers.
- R7: Pointer reads use the context-zero set (classes 2 to 4) when tag access bits 12:0 are all zero, and the nonzero set (classes 5 to 7) otherwise.
- R8: A read of class 8 at offset 0 returns the slot 0 pointer, built from the following fields:
  - the buffer size code, base bits 3:0;
  - the page size code, config bits 2:0;
  - a shifted value, tag access shifted right by 9 plus 3 times the page size code.
  Bits 4 up to 12 plus the buffer size code come from the shifted value, and every other bit below 13 is zero. The result is ORed with base bits 63:13, kept in place.
- R9: A read of class 9 at offset 0 returns the slot 1 pointer, computed the same way from the slot 1 base. When that base has bit 12 set, pointer bit 13 plus the buffer size code is also forced to one.
- R10: An access to an unmapped class or offset, or a write to class 1 offset 0, class 8 or class 9, gets rsp_err high and changes no register.
- R11: After reset every register reads zero.
- R12: A read returns register state from before any update made in the same cycle, including a same-cycle miss update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 4 | Address-space class |
| req_offset | input | OFS_W | Byte offset within the class |
| req_wdata | input | 64 | Write data |
| miss_valid | input | 1 | Load tag access from the miss port |
| miss_va | input | 64 | Missing virtual address |
| miss_ctx | input | 13 | Context of the missing access |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Access was unmapped or illegal |
| rsp_rdata | output | 64 | Read data |

## Verification
A corrupted tag access register, or a wrong choice of base set, does not show until the next read of a pointer, the tag target or tag access itself. That read exposes it one cycle after it is issued. The pointer tests therefore use shift amounts and buffer sizes that make each bit field visible. They cover the smallest and largest page size codes, a buffer size of 15, and the split bit set and clear. Each field is read straight after the miss update or write that should have changed it. Rejected writes are followed by reads of the register they might have hit, so a leaked write appears in the read data.

// File: rtl/mmu_tsb_pkg.sv
package mmu_tsb_pkg;

   localparam int DATA_W   = 64;
   localparam int SPACE_W  = 4;
   localparam int TAGCTX_W = 13;

   // address-space classes
   localparam logic [SPACE_W-1:0] SP_CTX  = 4'd0;
   localparam logic [SPACE_W-1:0] SP_XLAT = 4'd1;
   localparam logic [SPACE_W-1:0] SP_BZ0  = 4'd2;
   localparam logic [SPACE_W-1:0] SP_BZ1  = 4'd3;
   localparam logic [SPACE_W-1:0] SP_CZ   = 4'd4;
   localparam logic [SPACE_W-1:0] SP_BN0  = 4'd5;
   localparam logic [SPACE_W-1:0] SP_BN1  = 4'd6;
   localparam logic [SPACE_W-1:0] SP_CN   = 4'd7;
   localparam logic [SPACE_W-1:0] SP_PTR0 = 4'd8;
   localparam logic [SPACE_W-1:0] SP_PTR1 = 4'd9;

   typedef enum logic [3:0] {
      RG_PCTX, RG_SCTX, RG_TAG, RG_PART, RG_TTGT,
      RG_BASE_Z0, RG_BASE_Z1, RG_CFG_Z,
      RG_BASE_N0, RG_BASE_N1, RG_CFG_N,
      RG_PTR0, RG_PTR1, RG_NONE
   } reg_sel_e;

endpackage

// File: rtl/mmu_tsb_decode.sv
module mmu_tsb_decode
   import mmu_tsb_pkg::*;
#(
   parameter int OFS_W = 12
) (
   input  logic [SPACE_W-1:0] space,
   input  logic [OFS_W-1:0]   offset,
   input  logic               write,
   output reg_sel_e           sel,
   output logic               err
);

   localparam logic [OFS_W-1:0] OF_ZERO = '0;
   localparam logic [OFS_W-1:0] OF_PCTX = OFS_W'(8'h08);
   localparam logic [OFS_W-1:0] OF_SCTX = OFS_W'(8'h10);
   localparam logic [OFS_W-1:0] OF_TAG  = OFS_W'(8'h30);
   localparam logic [OFS_W-1:0] OF_PART = OFS_W'(8'h80);

   logic read_only;

   always_comb begin
      sel = RG_NONE;
      unique case (space)
         SP_CTX: begin
            if (offset == OF_PCTX)      sel = RG_PCTX;
            else if (offset == OF_SCTX) sel = RG_SCTX;
         end
         SP_XLAT: begin
            if (offset == OF_ZERO)      sel = RG_TTGT;
            else if (offset == OF_TAG)  sel = RG_TAG;
            else if (offset == OF_PART) sel = RG_PART;
         end
         SP_BZ0:  if (offset == OF_ZERO) sel = RG_BASE_Z0;
         SP_BZ1:  if (offset == OF_ZERO) sel = RG_BASE_Z1;
         SP_CZ:   if (offset == OF_ZERO) sel = RG_CFG_Z;
         SP_BN0:  if (offset == OF_ZERO) sel = RG_BASE_N0;
         SP_BN1:  if (offset == OF_ZERO) sel = RG_BASE_N1;
         SP_CN:   if (offset == OF_ZERO) sel = RG_CFG_N;
         SP_PTR0: if (offset == OF_ZERO) sel = RG_PTR0;
         SP_PTR1: if (offset == OF_ZERO) sel = RG_PTR1;
         default: sel = RG_NONE;
      endcase
   end

   assign read_only = (sel == RG_TTGT) || (sel == RG_PTR0) || (sel == RG_PTR1);
   assign err       = (sel == RG_NONE) || (write && read_only);

endmodule

// File: rtl/mmu_tsb_ptr.sv
module mmu_tsb_ptr
   import mmu_tsb_pkg::*;
#(
   parameter bit HAS_SPLIT = 1'b0,
   parameter int PS_W      = 3,
   parameter int BS_W      = 4
) (
   input  logic [DATA_W-1:0] tag_acc,
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] cfg,
   output logic [DATA_W-1:0] ptr
);

   localparam int SH_MAX  = 9 + 3 * ((1 << PS_W) - 1);
   localparam int TOP_MAX = 13 + ((1 << BS_W) - 1);

   initial begin
      if (SH_MAX >= DATA_W)  $error("page size code too wide");
      if (TOP_MAX >= DATA_W) $error("buffer size code too wide");
   end

   logic [PS_W-1:0]   ps;
   logic [BS_W-1:0]   bs;
   logic [6:0]        shamt;
   logic [6:0]        top;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] field_mask;
   logic [DATA_W-1:0] core;

   assign ps         = cfg[PS_W-1:0];
   assign bs         = base[BS_W-1:0];
   assign shamt      = 7'd9 + 7'(ps) * 7'd3;
   assign top        = 7'd13 + 7'(bs);
   assign shifted    = tag_acc >> shamt;
   assign field_mask = ((DATA_W'(1) << top) - DATA_W'(1)) & ~DATA_W'(16'hF);
   assign core       = {base[DATA_W-1:13], 13'd0} | (shifted & field_mask);

   generate
      if (HAS_SPLIT) begin : g_split
         assign ptr = core | ((base[12] ? DATA_W'(1) : DATA_W'(0)) << top);
      end else begin : g_plain
         assign ptr = core;
      end
   endgenerate

endmodule

// File: rtl/mmu_tsb_regfile.sv
module mmu_tsb_regfile
   import mmu_tsb_pkg::*;
#(
   parameter int OFS_W  = 12,
   parameter int CTX_W  = 13,
   parameter int PART_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [SPACE_W-1:0]  req_space,
   input  logic [OFS_W-1:0]    req_offset,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic                miss_valid,
   input  logic [DATA_W-1:0]   miss_va,
   input  logic [TAGCTX_W-1:0] miss_ctx,
   output logic                rsp_valid,
   output logic                rsp_err,
   output logic [DATA_W-1:0]   rsp_rdata
);

   localparam int NSET  = 2;
   localparam int NSLOT = 2;

   initial begin
      if (OFS_W < 8)                   $error("OFS_W must reach offset 0x80");
      if (CTX_W < 1 || CTX_W > 32)     $error("CTX_W out of range");
      if (PART_W < 1 || PART_W > 32)   $error("PART_W out of range");
   end

   reg_sel_e            sel;
   logic                dec_err;
   logic                wr_ok;
   logic [CTX_W-1:0]    pctx_q, sctx_q;
   logic [PART_W-1:0]   part_q;
   logic [DATA_W-1:0]   tag_q;
   logic [DATA_W-1:0]   base_q [NSET][NSLOT];
   logic [DATA_W-1:0]   cfg_q  [NSET];
   logic                use_nz;
   logic [DATA_W-1:0]   ptr    [NSLOT];
   logic [DATA_W-1:0]   ttgt;
   logic [DATA_W-1:0]   rd_mux;

   mmu_tsb_decode #(.OFS_W(OFS_W)) u_dec (
      .space  (req_space),
      .offset (req_offset),
      .write  (req_write),
      .sel    (sel),
      .err    (dec_err)
   );

   assign wr_ok  = req_valid && req_write && !dec_err;
   assign use_nz = (tag_q[TAGCTX_W-1:0] != '0);

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_ptr
         mmu_tsb_ptr #(.HAS_SPLIT(s == 1)) u_ptr (
            .tag_acc (tag_q),
            .base    (base_q[use_nz][s]),
            .cfg     (cfg_q[use_nz]),
            .ptr     (ptr[s])
         );
      end
   endgenerate

   assign ttgt = {3'd0, tag_q[TAGCTX_W-1:0], 6'd0, tag_q[DATA_W-1:22]};

   always_comb begin
      rd_mux = '0;
      unique case (sel)
         RG_PCTX:    rd_mux = DATA_W'(pctx_q);
         RG_SCTX:    rd_mux = DATA_W'(sctx_q);
         RG_TAG:     rd_mux = tag_q;
         RG_PART:    rd_mux = DATA_W'(part_q);
         RG_TTGT:    rd_mux = ttgt;
         RG_BASE_Z0: rd_mux = base_q[0][0];
         RG_BASE_Z1: rd_mux = base_q[0][1];
         RG_CFG_Z:   rd_mux = cfg_q[0];
         RG_BASE_N0: rd_mux = base_q[1][0];
         RG_BASE_N1: rd_mux = base_q[1][1];
         RG_CFG_N:   rd_mux = cfg_q[1];
         RG_PTR0:    rd_mux = ptr[0];
         RG_PTR1:    rd_mux = ptr[1];
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pctx_q <= '0;
         sctx_q <= '0;
         part_q <= '0;
         tag_q  <= '0;
         for (int i = 0; i < NSET; i++) begin
            cfg_q[i] <= '0;
            for (int j = 0; j < NSLOT; j++) base_q[i][j] <= '0;
         end
      end else begin
         if (wr_ok) begin
            unique case (sel)
               RG_PCTX:    pctx_q       <= req_wdata[CTX_W-1:0];
               RG_SCTX:    sctx_q       <= req_wdata[CTX_W-1:0];
               RG_PART:    part_q       <= req_wdata[PART_W-1:0];
               RG_BASE_Z0: base_q[0][0] <= req_wdata;
               RG_BASE_Z1: base_q[0][1] <= req_wdata;
               RG_CFG_Z:   cfg_q[0]     <= req_wdata;
               RG_BASE_N0: base_q[1][0] <= req_wdata;
               RG_BASE_N1: base_q[1][1] <= req_wdata;
               RG_CFG_N:   cfg_q[1]     <= req_wdata;
               default: ;
            endcase
         end
         if (miss_valid)
            tag_q <= {miss_va[DATA_W-1:TAGCTX_W], miss_ctx};
         else if (wr_ok && sel == RG_TAG)
            tag_q <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && dec_err;
         rsp_rdata <= (req_valid && !req_write && !dec_err) ? rd_mux : '0;
      end
   end

endmodule

// File: rtl/mmu_tsb_regfile_chk.sv
module mmu_tsb_regfile_chk
   import mmu_tsb_pkg::*;
#(
   parameter int OFS_W  = 12,
   parameter int CTX_W  = 13,
   parameter int PART_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_write,
   input logic [SPACE_W-1:0]  req_space,
   input logic [OFS_W-1:0]    req_offset,
   input logic                rsp_valid,
   input logic                rsp_err,
   input logic [DATA_W-1:0]   rsp_rdata
);

   logic rd_ptr, rd_ctx, rd_ttgt, rd_part;

   assign rd_ptr  = req_valid && !req_write && (req_space == SP_PTR0 || req_space == SP_PTR1)
                    && req_offset == '0;
   assign rd_ctx  = req_valid && !req_write && req_space == SP_CTX
                    && (req_offset == OFS_W'(8'h08) || req_offset == OFS_W'(8'h10));
   assign rd_ttgt = req_valid && !req_write && req_space == SP_XLAT && req_offset == '0;
   assign rd_part = req_valid && !req_write && req_space == SP_XLAT && req_offset == OFS_W'(8'h80);

   p_rsp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_write_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> rsp_rdata == '0);

   p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == '0));

   p_ctx_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ctx |=> (rsp_rdata[DATA_W-1:CTX_W] == '0 && !rsp_err));

   p_part_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_part |=> (rsp_rdata[DATA_W-1:PART_W] == '0 && !rsp_err));

   p_ttgt_gaps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ttgt |=> (rsp_rdata[47:42] == '0 && rsp_rdata[63:61] == '0));

   p_ptr_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr |=> (rsp_rdata[3:0] == 4'd0 && !rsp_err));

endmodule

bind mmu_tsb_regfile mmu_tsb_regfile_chk #(
   .OFS_W(OFS_W), .CTX_W(CTX_W), .PART_W(PART_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_space  (req_space),
   .req_offset (req_offset),
   .rsp_valid  (rsp_valid),
   .rsp_err    (rsp_err),
   .rsp_rdata  (rsp_rdata)
);

// File: tb/mmu_tsb_regfile_tb.sv
module mmu_tsb_regfile_tb;

   typedef struct {
      logic        err;
      logic [63:0] data;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_space = '0;
   logic [11:0] req_offset = '0;
   logic [63:0] req_wdata = '0;
   logic        miss_valid = 1'b0;
   logic [63:0] miss_va = '0;
   logic [12:0] miss_ctx = '0;
   logic        rsp_valid;
   logic        rsp_err;
   logic [63:0] rsp_rdata;

   int   n_checks = 0;
   int   n_errors = 0;
   exp_t sb[$];

   // bench model of the register state
   logic [63:0] m_pctx, m_sctx, m_part, m_tag;
   logic [63:0] m_base [2][2];
   logic [63:0] m_cfg  [2];

   always #5 clk = ~clk;

   mmu_tsb_regfile u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_space(req_space), .req_offset(req_offset), .req_wdata(req_wdata),
      .miss_valid(miss_valid), .miss_va(miss_va), .miss_ctx(miss_ctx),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   function automatic logic [63:0] exp_ptr(input logic [63:0] ta, input logic [63:0] b,
                                           input logic [63:0] c, input bit slot1);
      logic [63:0] r, sh;
      int bsz, psz;
      bsz = int'(b[3:0]);
      psz = int'(c[2:0]);
      sh  = ta >> (9 + 3 * psz);
      r   = b & ~64'h1FFF;
      for (int k = 4; k <= 12 + bsz; k++) r[k] = r[k] | sh[k];
      if (slot1 && b[12]) r[13 + bsz] = 1'b1;
      return r;
   endfunction

   task automatic model_reset();
      m_pctx = '0; m_sctx = '0; m_part = '0; m_tag = '0;
      for (int i = 0; i < 2; i++) begin
         m_cfg[i] = '0;
         for (int j = 0; j < 2; j++) m_base[i][j] = '0;
      end
   endtask

   // driver: computes expectation from the model, pushes it, drives one cycle
   task automatic access(input logic [3:0] sp, input logic [11:0] ofs, input bit we,
                         input logic [63:0] wd, input bit mv, input logic [63:0] mva,
                         input logic [12:0] mctx, input string tag);
      exp_t e;
      bit   ok, ro;
      logic [63:0] rd;
      int   set;
      ok = 1'b0; ro = 1'b0; rd = '0;
      set = (m_tag[12:0] != 13'd0) ? 1 : 0;
      case (sp)
         4'd0: if (ofs == 12'h008) begin ok = 1; rd = m_pctx; end
               else if (ofs == 12'h010) begin ok = 1; rd = m_sctx; end
         4'd1: if (ofs == 12'h000) begin ok = 1; ro = 1;
                  rd = {3'd0, m_tag[12:0], 6'd0, m_tag[63:22]}; end
               else if (ofs == 12'h030) begin ok = 1; rd = m_tag; end
               else if (ofs == 12'h080) begin ok = 1; rd = m_part; end
         4'd2, 4'd3, 4'd5, 4'd6: if (ofs == 0) begin ok = 1;
                  rd = m_base[(sp >= 4'd5) ? 1 : 0][(sp == 4'd3 || sp == 4'd6) ? 1 : 0]; end
         4'd4: if (ofs == 0) begin ok = 1; rd = m_cfg[0]; end
         4'd7: if (ofs == 0) begin ok = 1; rd = m_cfg[1]; end
         4'd8, 4'd9: if (ofs == 0) begin ok = 1; ro = 1;
                  rd = exp_ptr(m_tag, m_base[set][sp == 4'd9], m_cfg[set], sp == 4'd9); end
         default: ok = 0;
      endcase
      e.err  = !ok || (we && ro);
      e.data = (e.err || we) ? 64'd0 : rd;
      e.tag  = tag;
      sb.push_back(e);
      if (we && !e.err) begin
         case (sp)
            4'd0: if (ofs == 12'h008) m_pctx = {51'd0, wd[12:0]}; else m_sctx = {51'd0, wd[12:0]};
            4'd1: if (ofs == 12'h030) m_tag = wd; else m_part = {56'd0, wd[7:0]};
            4'd2: m_base[0][0] = wd;
            4'd3: m_base[0][1] = wd;
            4'd4: m_cfg[0] = wd;
            4'd5: m_base[1][0] = wd;
            4'd6: m_base[1][1] = wd;
            4'd7: m_cfg[1] = wd;
            default: ;
         endcase
      end
      if (mv) m_tag = {mva[63:13], mctx};
      req_valid = 1'b1; req_write = we; req_space = sp; req_offset = ofs; req_wdata = wd;
      miss_valid = mv; miss_va = mva; miss_ctx = mctx;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; miss_valid = 1'b0;
   endtask

   task automatic rd(input logic [3:0] sp, input logic [11:0] ofs, input string tag);
      access(sp, ofs, 1'b0, 64'd0, 1'b0, 64'd0, 13'd0, tag);
   endtask

   task automatic wr(input logic [3:0] sp, input logic [11:0] ofs, input logic [63:0] d,
                     input string tag);
      access(sp, ofs, 1'b1, d, 1'b0, 64'd0, 13'd0, tag);
   endtask

   // monitor: pops and compares each response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            n_checks++; n_errors++;
            $display("FAIL R1: unexpected response err=%0b data=%h, expected none", rsp_err, rsp_rdata);
         end else begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (rsp_err !== e.err || rsp_rdata !== e.data) begin
               n_errors++;
               $display("FAIL %s: got err=%0b data=%h, expected err=%0b data=%h",
                        e.tag, rsp_err, rsp_rdata, e.err, e.data);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_errors++; n_checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      rd(4'd0, 12'h008, "R11");
      rd(4'd1, 12'h030, "R11");
      rd(4'd1, 12'h080, "R11");
      rd(4'd2, 12'h000, "R11");
      rd(4'd7, 12'h000, "R11");
      rd(4'd8, 12'h000, "R11");
      rd(4'd1, 12'h000, "R11");
      // R2 contexts, width trimming
      wr(4'd0, 12'h008, 64'hFFFF_FFFF_FFFF_1ABC, "R2");
      wr(4'd0, 12'h010, 64'h0000_0000_0000_0155, "R2");
      rd(4'd0, 12'h008, "R2");
      rd(4'd0, 12'h010, "R2");
      // R3 tag access and partition
      wr(4'd1, 12'h030, 64'hFEDC_BA98_7654_3210, "R3");
      wr(4'd1, 12'h080, 64'h0000_0000_0000_01FF, "R3");
      rd(4'd1, 12'h030, "R3");
      rd(4'd1, 12'h080, "R3");
      // R4 tag target
      rd(4'd1, 12'h000, "R4");
      // R6 base/config storage
      wr(4'd5, 12'h000, 64'h0000_1234_5678_A003, "R6");
      wr(4'd7, 12'h000, 64'h0000_0000_0000_0001, "R6");
      wr(4'd6, 12'h000, 64'h0000_0ABC_DEF0_1005, "R6");
      wr(4'd2, 12'h000, 64'h0000_0000_4000_000F, "R6");
      wr(4'd4, 12'h000, 64'h0000_0000_0000_0007, "R6");
      wr(4'd3, 12'h000, 64'h0000_0000_8000_2008, "R6");
      rd(4'd5, 12'h000, "R6");
      rd(4'd6, 12'h000, "R6");
      rd(4'd4, 12'h000, "R6");
      // R7 R8 R9 pointers with nonzero context (split on slot 1)
      rd(4'd8, 12'h000, "R8");
      rd(4'd9, 12'h000, "R9");
      // R5 miss update with context zero; R7 set switch
      access(4'd1, 12'h030, 1'b0, 64'd0, 1'b1, 64'h1234_5678_9ABC_DEF0, 13'd0, "R12");
      rd(4'd1, 12'h030, "R5");
      rd(4'd8, 12'h000, "R7");
      rd(4'd9, 12'h000, "R7");
      // R5 miss beats same-cycle write
      access(4'd1, 12'h030, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 64'hFFFF_0000_FFFF_E000,
             13'h0ABC, "R5");
      rd(4'd1, 12'h030, "R5");
      rd(4'd1, 12'h000, "R4");
      rd(4'd8, 12'h000, "R8");
      // R9 split clear in nonzero set, page size 0
      wr(4'd7, 12'h000, 64'h0000_0000_0000_0000, "R6");
      wr(4'd6, 12'h000, 64'h0000_0000_0000_E000, "R6");
      rd(4'd9, 12'h000, "R9");
      // R10 errors and no side effects
      rd(4'd0, 12'h018, "R10");
      rd(4'd10, 12'h000, "R10");
      wr(4'd8, 12'h000, 64'h1111, "R10");
      wr(4'd1, 12'h000, 64'h2222, "R10");
      wr(4'd2, 12'h008, 64'h3333, "R10");
      wr(4'd15, 12'h030, 64'h4444, "R10");
      rd(4'd2, 12'h000, "R10");
      rd(4'd1, 12'h030, "R10");
      repeat (4) @(negedge clk);
      n_checks++;
      if (sb.size() != 0) begin
         n_errors++;
         $display("FAIL R1: %0d responses missing, expected 0", sb.size());
      end
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule